// File: doc/BRIEF.md
# Configurable Logic-Cell Output Stage

This block is the output stage of one logic cell in a product-term programmable logic device. It receives five product terms from the AND array and a static configuration word. A selection stage decides, term by term, whether a product term feeds the sum or drives a register control function. The sum is an OR of the unrouted terms followed by an XOR. The XOR operand is either a fixed polarity bit or an auxiliary product term, so the sum can be inverted.

The sum either goes straight to the cell output (register bypass) or updates a one-bit register. The register can behave as a D, T, JK or SR flip-flop. Its clock comes from one of two global clocks or from a product term. It can have a product-term clock enable. Its preset and clear are asynchronous, and its clear can also come from a global active-low pin. A fast-input path loads a pin value directly into the register, skipping the sum logic.

The register value is also driven out on its own port, as the feedback into the interconnect. The configuration word is meant to be held constant while the cell runs.

Top module: `mcell_top`

## Requirements
- R1: The sum is the OR of every product term whose route bit (cfgWord[i] for term i) is 0, XORed with an operand. The operand is the auxiliary term (prodTerm[0] AND cfgWord[0]) when cfgWord[5] is 1, and cfgWord[6] when cfgWord[5] is 0.
- R2: The register kind is set by cfgWord[8:7]: 00 D, 01 T, 10 JK, 11 SR. For T, JK and SR, the first input is the sum. For JK and SR, the second input (K or R) is the auxiliary term. J=K=1 toggles the register. S=R=1 holds it.
- R3: When cfgWord[9] is 1, cellOut equals the sum combinationally. When cfgWord[9] is 0, cellOut equals the register. regFb always equals the register.
- R4: Clock mode cfgWord[12:11]=00, and the spare code 11, clock the register on the selected global clock with no enable. In these modes prodTerm[4] has no effect.
- R5: Clock mode 01 loads the register on the selected global clock only while the enable is high. The enable is prodTerm[4] when cfgWord[4]=1, and is held high when cfgWord[4]=0.
- R6: Clock mode 10 clocks the register on the rising edge of prodTerm[3] AND cfgWord[3]. Global clock edges then do not load the register.
- R7: Global clock k is the pin gclkPin[cfgWord[14+k]] XOR cfgWord[16+k]. cfgWord[13] selects which global clock the cell uses.
- R8: When cfgWord[2]=1, prodTerm[2] is an active-high asynchronous preset. When cfgWord[1]=1, prodTerm[1] is an active-high asynchronous clear. When both are active, clear wins.
- R9: When cfgWord[18]=1, globalClrN low clears the register asynchronously. When cfgWord[18]=0, globalClrN has no effect.
- R10: While porN is low, the register is 0.
- R11: When cfgWord[10]=1, the register loads fastPin on each active clock. The sum and the register kind are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| porN | input | 1 | Active-low power-on clear of the register |
| gclkPin | input | 2 | Global clock pins |
| globalClrN | input | 1 | Active-low global clear pin, used only when the cell selects it |
| fastPin | input | 1 | Pin value for the fast-input path |
| prodTerm | input | 5 | Product terms from the AND array |
| cfgWord | input | 19 | Static cell configuration |
| cellOut | output | 1 | Cell output: the sum, or the register value |
| regFb | output | 1 | Register value fed back to the interconnect |

## Verification
The main test drives random product terms through all four register kinds. Random route masks, XOR operand choices and bypass settings are mixed in, and each step is compared with a bench model. This separates errors in the OR mask, the XOR operand and the next-state rules, which a single fixed pattern would hide. Directed cases then cover the clock sources, enable gating, the asynchronous priorities and the fast-input path. In each of these cases a pattern is chosen so that the sum and the expected register value differ. This way, a wrong source or a wrong priority shows up as a wrong bit.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;

  // Cell dimensions
  localparam int PT_COUNT   = 5;
  localparam int GCLK_COUNT = 2;
  localparam int GPIN_COUNT = 2;
  localparam int GPIN_SEL_W = (GPIN_COUNT > 1) ? $clog2(GPIN_COUNT) : 1;
  localparam int GCLK_SEL_W = (GCLK_COUNT > 1) ? $clog2(GCLK_COUNT) : 1;

  // Fixed role of each product term when routed to control
  localparam int PT_AUX  = 0;  // XOR operand / K / R
  localparam int PT_CLR  = 1;  // asynchronous clear
  localparam int PT_SET  = 2;  // asynchronous preset
  localparam int PT_ACLK = 3;  // array clock
  localparam int PT_CEN  = 4;  // clock enable

  typedef enum logic [1:0] {
    REG_D  = 2'b00,
    REG_T  = 2'b01,
    REG_JK = 2'b10,
    REG_SR = 2'b11
  } regKind_e;

  typedef enum logic [1:0] {
    CLK_GLOBAL     = 2'b00,
    CLK_GLOBAL_EN  = 2'b01,
    CLK_ARRAY      = 2'b10,
    CLK_GLOBAL_ALT = 2'b11
  } clkMode_e;

  // Configuration word, most significant field first
  typedef struct packed {
    logic                                   useGlobalClr;
    logic [GCLK_COUNT-1:0]                  gInv;
    logic [GCLK_COUNT-1:0][GPIN_SEL_W-1:0]  gPinSel;
    logic [GCLK_SEL_W-1:0]                  cellGclk;
    clkMode_e                               clkMode;
    logic                                   fastSel;
    logic                                   bypass;
    regKind_e                               regMode;
    logic                                   xorInv;
    logic                                   xorUsePt;
    logic [PT_COUNT-1:0]                    ptRoute;
  } cellCfg_t;

  localparam int CFG_W = $bits(cellCfg_t);

  // Strobes from control to datapath
  typedef struct packed {
    logic cellClk;
    logic loadEn;
    logic asyncClr;
    logic asyncSet;
  } regStrobe_t;

endpackage

// File: rtl/mcell_ctrl.sv
`timescale 1ns/1ps
module mcell_ctrl
  import mcell_pkg::*;
#(
  parameter int NUM_PT   = PT_COUNT,
  parameter int NUM_GCLK = GCLK_COUNT,
  parameter int NUM_GPIN = GPIN_COUNT,
  localparam int PSEL_W  = (NUM_GPIN > 1) ? $clog2(NUM_GPIN) : 1,
  localparam int CSEL_W  = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                             porN,
  input  logic                             globalClrN,
  input  logic [NUM_GPIN-1:0]              gclkPin,
  input  logic [NUM_PT-1:1]                ctlTerm,
  input  logic [NUM_PT-1:1]                ctlRoute,
  input  clkMode_e                         clkMode,
  input  logic [CSEL_W-1:0]                cellGclk,
  input  logic [NUM_GCLK-1:0][PSEL_W-1:0]  gPinSel,
  input  logic [NUM_GCLK-1:0]              gInv,
  input  logic                             useGlobalClr,
  output regStrobe_t                       stb
);

  logic [NUM_GCLK-1:0] globalClk;
  logic                selGlobal;
  logic                clrTerm;
  logic                setTerm;
  logic                arrayClk;
  logic                cenTerm;
  logic                clkMux;
  logic                enMux;

  // Build each global clock from a chosen pin and polarity
  for (genvar k = 0; k < NUM_GCLK; k++) begin : g_gclk
    assign globalClk[k] = gclkPin[gPinSel[k]] ^ gInv[k];
  end

  assign selGlobal = globalClk[cellGclk];

  // Control terms are live only when steered away from the sum
  assign clrTerm  = ctlRoute[PT_CLR]  & ctlTerm[PT_CLR];
  assign setTerm  = ctlRoute[PT_SET]  & ctlTerm[PT_SET];
  assign arrayClk = ctlRoute[PT_ACLK] & ctlTerm[PT_ACLK];
  assign cenTerm  = ctlRoute[PT_CEN]  ? ctlTerm[PT_CEN] : 1'b1;

  always_comb begin
    unique case (clkMode)
      CLK_ARRAY: begin
        clkMux = arrayClk;
        enMux  = 1'b1;
      end
      CLK_GLOBAL_EN: begin
        clkMux = selGlobal;
        enMux  = cenTerm;
      end
      default: begin
        clkMux = selGlobal;
        enMux  = 1'b1;
      end
    endcase
  end

  assign stb.cellClk  = clkMux;
  assign stb.loadEn   = enMux;
  assign stb.asyncClr = ~porN | clrTerm | (useGlobalClr & ~globalClrN);
  assign stb.asyncSet = setTerm;

endmodule

// File: rtl/mcell_dp.sv
`timescale 1ns/1ps
module mcell_dp
  import mcell_pkg::*;
#(
  parameter int NUM_PT = PT_COUNT
) (
  input  logic              fastPin,
  input  logic [NUM_PT-1:0] prodTerm,
  input  logic [NUM_PT-1:0] ptRoute,
  input  logic              xorUsePt,
  input  logic              xorInv,
  input  regKind_e          regMode,
  input  logic              bypass,
  input  logic              fastSel,
  input  regStrobe_t        stb,
  output logic              regQ,
  output logic              cellOut
);

  logic [NUM_PT-1:0] sumTerm;
  logic              orSum;
  logic              auxTerm;
  logic              xorOperand;
  logic              sumX;
  logic              kindNext;
  logic              nextQ;
  logic              clkI;
  logic              clrI;
  logic              setI;
  logic              enI;

  // Terms not steered to control feed the OR
  for (genvar i = 0; i < NUM_PT; i++) begin : g_sum
    assign sumTerm[i] = prodTerm[i] & ~ptRoute[i];
  end

  assign orSum      = |sumTerm;
  assign auxTerm    = ptRoute[PT_AUX] & prodTerm[PT_AUX];
  assign xorOperand = xorUsePt ? auxTerm : xorInv;
  assign sumX       = orSum ^ xorOperand;

  // Next-state rules for each register kind
  always_comb begin
    unique case (regMode)
      REG_T:  kindNext = regQ ^ sumX;
      REG_JK: begin
        unique case ({sumX, auxTerm})
          2'b10:   kindNext = 1'b1;
          2'b01:   kindNext = 1'b0;
          2'b11:   kindNext = ~regQ;
          default: kindNext = regQ;
        endcase
      end
      REG_SR: begin
        unique case ({sumX, auxTerm})
          2'b10:   kindNext = 1'b1;
          2'b01:   kindNext = 1'b0;
          default: kindNext = regQ;
        endcase
      end
      default: kindNext = sumX;
    endcase
  end

  assign nextQ = fastSel ? fastPin : kindNext;

  assign clkI = stb.cellClk;
  assign clrI = stb.asyncClr;
  assign setI = stb.asyncSet;
  assign enI  = stb.loadEn;

  // Clear has priority over preset
  always_ff @(posedge clkI or posedge clrI or posedge setI) begin
    if (clrI) begin
      regQ <= 1'b0;
    end else if (setI) begin
      regQ <= 1'b1;
    end else if (enI) begin
      regQ <= nextQ;
    end
  end

  assign cellOut = bypass ? sumX : regQ;

endmodule

// File: rtl/mcell_top.sv
`timescale 1ns/1ps
module mcell_top
  import mcell_pkg::*;
(
  input  logic                  porN,
  input  logic [GPIN_COUNT-1:0] gclkPin,
  input  logic                  globalClrN,
  input  logic                  fastPin,
  input  logic [PT_COUNT-1:0]   prodTerm,
  input  logic [CFG_W-1:0]      cfgWord,
  output logic                  cellOut,
  output logic                  regFb
);

  cellCfg_t   cfg;
  regStrobe_t stb;

  assign cfg = cellCfg_t'(cfgWord);

  mcell_ctrl #(
    .NUM_PT   (PT_COUNT),
    .NUM_GCLK (GCLK_COUNT),
    .NUM_GPIN (GPIN_COUNT)
  ) ctrlI (
    .porN         (porN),
    .globalClrN   (globalClrN),
    .gclkPin      (gclkPin),
    .ctlTerm      (prodTerm[PT_COUNT-1:1]),
    .ctlRoute     (cfg.ptRoute[PT_COUNT-1:1]),
    .clkMode      (cfg.clkMode),
    .cellGclk     (cfg.cellGclk),
    .gPinSel      (cfg.gPinSel),
    .gInv         (cfg.gInv),
    .useGlobalClr (cfg.useGlobalClr),
    .stb          (stb)
  );

  mcell_dp #(
    .NUM_PT (PT_COUNT)
  ) dpI (
    .fastPin  (fastPin),
    .prodTerm (prodTerm),
    .ptRoute  (cfg.ptRoute),
    .xorUsePt (cfg.xorUsePt),
    .xorInv   (cfg.xorInv),
    .regMode  (cfg.regMode),
    .bypass   (cfg.bypass),
    .fastSel  (cfg.fastSel),
    .stb      (stb),
    .regQ     (regFb),
    .cellOut  (cellOut)
  );

endmodule

// File: rtl/mcell_chk.sv
`timescale 1ns/1ps
module mcell_chk
  import mcell_pkg::*;
(
  input logic     gclk,
  input logic     porN,
  input logic     asyncClr,
  input logic     asyncSet,
  input logic     loadEn,
  input logic     fastSel,
  input logic     pin0Direct,
  input logic     fastPin,
  input logic     regQ,
  input clkMode_e clkMode
);

  // R8
  clear_wins_chk: assert property (@(posedge gclk) disable iff (!porN)
    asyncClr |-> (regQ == 1'b0));

  // R8
  preset_hold_chk: assert property (@(posedge gclk) disable iff (!porN)
    (asyncSet && !asyncClr) |-> (regQ == 1'b1));

  // R5
  enable_hold_chk: assert property (@(posedge gclk) disable iff (!porN)
    (clkMode == CLK_GLOBAL_EN && !loadEn && !asyncClr && !asyncSet &&
     $past(clkMode == CLK_GLOBAL_EN && !loadEn && !asyncClr && !asyncSet))
    |-> $stable(regQ));

  // R11
  fast_load_chk: assert property (@(posedge gclk) disable iff (!porN)
    (fastSel && pin0Direct && clkMode == CLK_GLOBAL && !asyncClr && !asyncSet &&
     $past(fastSel && pin0Direct && clkMode == CLK_GLOBAL && !asyncClr && !asyncSet))
    |-> (regQ == $past(fastPin)));

endmodule

bind mcell_top mcell_chk chkI (
  .gclk       (gclkPin[0]),
  .porN       (porN),
  .asyncClr   (stb.asyncClr),
  .asyncSet   (stb.asyncSet),
  .loadEn     (stb.loadEn),
  .fastSel    (cfg.fastSel),
  .pin0Direct (cfg.cellGclk == '0 && cfg.gPinSel[0] == '0 && !cfg.gInv[0]),
  .fastPin    (fastPin),
  .regQ       (regFb),
  .clkMode    (cfg.clkMode)
);

// File: tb/mcell_top_test.sv
`timescale 1ns/1ps
module mcell_top_test;

  logic        clk = 1'b0;
  logic        pin1 = 1'b0;
  logic        porN = 1'b0;
  logic        gClrN = 1'b1;
  logic        fastPin = 1'b0;
  logic [4:0]  pt = '0;
  logic [18:0] cfg = '0;
  logic        cellOut;
  logic        regFb;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mcell_top uut (
    .porN       (porN),
    .gclkPin    ({pin1, clk}),
    .globalClrN (gClrN),
    .fastPin    (fastPin),
    .prodTerm   (pt),
    .cfgWord    (cfg),
    .cellOut    (cellOut),
    .regFb      (regFb)
  );

  // Configuration word built from field values
  function automatic logic [18:0] mkCfg(logic [4:0] route, logic usePt, logic inv,
      logic [1:0] kind, logic byp, logic fast, logic [1:0] cmode, logic gsel,
      logic [1:0] psel, logic [1:0] ginv, logic gclr);
    return {gclr, ginv, psel, gsel, cmode, fast, byp, kind, inv, usePt, route};
  endfunction

  function automatic logic fAux(logic [4:0] p, logic [18:0] c);
    return p[0] & c[0];
  endfunction

  function automatic logic fSum(logic [4:0] p, logic [18:0] c);
    logic orv;
    logic op;
    orv = |(p & ~c[4:0]);
    op  = c[5] ? fAux(p, c) : c[6];
    return orv ^ op;
  endfunction

  function automatic logic fNext(logic q, logic [4:0] p, logic [18:0] c, logic fp);
    logic s;
    logic a;
    s = fSum(p, c);
    a = fAux(p, c);
    if (c[10]) return fp;
    case (c[8:7])
      2'b00: return s;
      2'b01: return q ^ s;
      2'b10: return (s && a) ? ~q : (s ? 1'b1 : (a ? 1'b0 : q));
      default: return (s && !a) ? 1'b1 : ((!s && a) ? 1'b0 : q);
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Load a configuration while the register is held clear across one edge
  task automatic startCase(logic [18:0] c, logic [4:0] p);
    @(negedge clk);
    porN = 1'b0;
    cfg  = c;
    pt   = p;
    @(negedge clk);
    porN = 1'b1;
  endtask

  initial begin
    #100us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic        expQ;
    logic [18:0] rc;
    void'($urandom(32'd20240611));

    // R10: power-on clear
    cfg = mkCfg(5'b0, 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0);
    @(negedge clk);
    @(negedge clk);
    check("R10 reg during porN", regFb, 1'b0);
    check("R10 out during porN", cellOut, 1'b0);
    pt = 5'b00010;
    @(negedge clk);
    check("R10 still clear", regFb, 1'b0);

    // R1 directed: auxiliary term as XOR operand
    startCase(mkCfg(5'b00001, 1, 0, 2'b00, 1, 0, 2'b00, 0, 2'b00, 2'b00, 0), 5'b00001);
    #1 check("R1 aux operand", cellOut, 1'b1);
    pt = 5'b00101;
    #1 check("R1 aux inverts sum", cellOut, 1'b0);
    // R3 directed: bypass with polarity bit
    startCase(mkCfg(5'b0, 0, 1, 2'b00, 1, 0, 2'b00, 0, 2'b00, 2'b00, 0), 5'b00100);
    #1 check("R3 bypass inverted", cellOut, 1'b0);

    // R1 R2 R3 R4: random terms through all kinds
    rc = mkCfg(5'b0, 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0);
    startCase(rc, 5'b0);
    expQ = 1'b0;
    for (int it = 0; it < 600; it++) begin
      if (it % 25 == 0) begin
        rc = mkCfg({($urandom % 2) == 1, ($urandom % 2) == 1, 2'b00, ($urandom % 2) == 1},
                   ($urandom % 2) == 1, ($urandom % 2) == 1, 2'($urandom % 4),
                   ($urandom % 2) == 1, 0, (($urandom % 2) == 1) ? 2'b11 : 2'b00,
                   0, 2'b00, 2'b00, 0);
        cfg = rc;
      end
      pt = 5'($urandom % 32);
      #1;
      if (rc[9]) check("R1 sum on bypass", cellOut, fSum(pt, rc));
      else       check("R3 register on output", cellOut, expQ);
      expQ = fNext(expQ, pt, rc, fastPin);
      @(negedge clk);
      check("R2 register next state", regFb, expQ);
    end

    // R4: enable term ignored in global-only modes
    startCase(mkCfg(5'b10000, 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0), 5'b00010);
    @(negedge clk);
    check("R4 enable ignored mode 00", regFb, 1'b1);
    startCase(mkCfg(5'b10000, 0, 0, 2'b00, 0, 0, 2'b11, 0, 2'b00, 2'b00, 0), 5'b00010);
    @(negedge clk);
    check("R4 enable ignored mode 11", regFb, 1'b1);

    // R5: gated global clock
    startCase(mkCfg(5'b10000, 0, 0, 2'b00, 0, 0, 2'b01, 0, 2'b00, 2'b00, 0), 5'b00010);
    @(negedge clk);
    @(negedge clk);
    check("R5 enable low holds", regFb, 1'b0);
    pt[4] = 1'b1;
    @(negedge clk);
    check("R5 enable high loads", regFb, 1'b1);
    startCase(mkCfg(5'b00000, 0, 0, 2'b00, 0, 0, 2'b01, 0, 2'b00, 2'b00, 0), 5'b00010);
    @(negedge clk);
    check("R5 unrouted enable high", regFb, 1'b1);

    // R6: array clock
    startCase(mkCfg(5'b01000, 0, 0, 2'b00, 0, 0, 2'b10, 0, 2'b00, 2'b00, 0), 5'b00010);
    @(negedge clk);
    @(negedge clk);
    check("R6 global edges ignored", regFb, 1'b0);
    pt[3] = 1'b1;
    #1 check("R6 array edge loads", regFb, 1'b1);
    @(negedge clk);
    pt = 5'b0;
    #1 check("R6 falling edge holds", regFb, 1'b1);
    @(negedge clk);
    check("R6 still held", regFb, 1'b1);

    // R7: second global clock from pin 1, true then inverted
    pin1 = 1'b0;
    startCase(mkCfg(5'b0, 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b10, 2'b00, 0), 5'b00010);
    @(negedge clk);
    @(negedge clk);
    check("R7 pin0 edges ignored", regFb, 1'b0);
    pin1 = 1'b1;
    #1 check("R7 pin1 rising loads", regFb, 1'b1);
    startCase(mkCfg(5'b0, 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b10, 2'b10, 0), 5'b00010);
    @(negedge clk);
    check("R7 inverted waits", regFb, 1'b0);
    pin1 = 1'b0;
    #1 check("R7 pin1 falling loads when inverted", regFb, 1'b1);

    // R8: preset, clear and their priority
    startCase(mkCfg(5'b00110, 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0), 5'b0);
    pt[2] = 1'b1;
    #1 check("R8 preset async", regFb, 1'b1);
    @(negedge clk);
    check("R8 preset holds over edge", regFb, 1'b1);
    pt[1] = 1'b1;
    #1 check("R8 clear wins", regFb, 1'b0);
    @(negedge clk);
    pt[2] = 1'b0;
    #1 check("R8 clear alone", regFb, 1'b0);
    @(negedge clk);
    pt[1] = 1'b0;
    @(negedge clk);
    check("R8 released", regFb, 1'b0);

    // R9: global clear enabled and ignored
    startCase(mkCfg(5'b0, 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 2'b00, 1), 5'b00001);
    @(negedge clk);
    check("R9 loaded one", regFb, 1'b1);
    gClrN = 1'b0;
    #1 check("R9 global clear", regFb, 1'b0);
    @(negedge clk);
    gClrN = 1'b1;
    @(negedge clk);
    check("R9 reload after clear", regFb, 1'b1);
    startCase(mkCfg(5'b0, 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0), 5'b00001);
    @(negedge clk);
    gClrN = 1'b0;
    #1 check("R9 clear not selected", regFb, 1'b1);
    @(negedge clk);
    gClrN = 1'b1;

    // R11: fast input overrides sum and kind
    fastPin = 1'b0;
    startCase(mkCfg(5'b0, 0, 0, 2'b10, 0, 1, 2'b00, 0, 2'b00, 2'b00, 0), 5'b00010);
    @(negedge clk);
    check("R11 fast zero over sum", regFb, 1'b0);
    fastPin = 1'b1;
    @(negedge clk);
    check("R11 fast one", regFb, 1'b1);
    fastPin = 1'b0;
    @(negedge clk);
    check("R11 fast back to zero", regFb, 1'b0);

    // R2: JK toggle and SR hold
    startCase(mkCfg(5'b00001, 0, 0, 2'b10, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0), 5'b00011);
    @(negedge clk);
    check("R2 JK toggle up", regFb, 1'b1);
    @(negedge clk);
    check("R2 JK toggle down", regFb, 1'b0);
    startCase(mkCfg(5'b00001, 0, 0, 2'b11, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0), 5'b00010);
    @(negedge clk);
    check("R2 SR set", regFb, 1'b1);
    pt = 5'b00011;
    @(negedge clk);
    @(negedge clk);
    check("R2 SR both hold", regFb, 1'b1);
    pt = 5'b00001;
    @(negedge clk);
    check("R2 SR reset", regFb, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule